// File: doc/BRIEF.md
# Iterative Shift-Add CORDIC Engine (Rotation and Vectoring)

This block computes trigonometric functions with one shift-add micro-rotation per clock. In rotation mode it turns an input vector through a given angle: with a pre-scaled unit vector on the x input it returns cosine and sine. In vectoring mode it turns the input vector onto the positive x axis and returns the uncompensated magnitude and the accumulated angle, which is atan2(y, x).

Vector components are signed Q1.30 and angles are signed Q2.30, both 32 bits wide by default. The arctangent constants are generated inside the block. The caller must keep rotation angles within the convergence range of about ±1.74 rad, because the engine does no quadrant folding in rotation mode. The caller must also keep vectoring inputs small enough that 1.647 times their magnitude still fits.

There is no valid/ready stream here. The interface is single-issue: a `start` pulse launches one operation, `busy` covers the run, and `valid` marks its completion for one cycle. `valid` carries no back-pressure. The caller must capture the held results at any time before it issues the next `start`.

Top module: `cordic_iter_engine`

## Requirements
- R1: During and after reset, `busy` and `valid` are low and `x_out`, `y_out` and `z_out` are zero.
- R2: A `start` sampled while `busy` is low is accepted. `busy` is high from the next cycle on. `valid` is high for exactly one cycle, ITER clock edges after the accepting edge, and `busy` falls on that same edge.
- R3: A `start` sampled while `busy` is high is ignored. The running operation keeps its operands, its results and its completion cycle.
- R4: Results stay unchanged on `x_out`, `y_out` and `z_out` from the `valid` pulse until the next accepted `start`.
- R5: With `mode` = 0 (rotation), each step turns in the direction of the sign of z, with zero counting as positive. With x_in = 652032874 (1/K for ITER = 16), y_in = 0 and |z_in| ≤ 1.5 rad, `x_out` and `y_out` are within 40000 LSB of cos(z_in)·2^30 and sin(z_in)·2^30.
- R6: With `mode` = 1 (vectoring), each step turns against the sign of y. `x_out` is within 4096 LSB of 1.6467602·sqrt(x²+y²). `y_out` is within 40000 LSB of 0. `z_out` is within 40000 LSB of z_in + atan2(y, x) in Q2.30, for x ≥ 0.
- R7: In vectoring mode, a negative x_in makes the engine negate both x and y before iterating. An input at 180° therefore gives the same angle as one at 0°, and (−x, y) gives the angle of (x, −y).
- R8: x and y are shifted arithmetically, so negative angles and negative components give correctly signed results.
- R9: A `start` presented in the cycle that shows `valid` is accepted. Operations can run back to back with one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, sampled while idle |
| mode | input | 1 | 0 = rotation, 1 = vectoring |
| x_in | input | WIDTH | Initial x, signed Q1.30 |
| y_in | input | WIDTH | Initial y, signed Q1.30 |
| z_in | input | WIDTH | Initial angle, signed Q2.30 |
| busy | output | 1 | Operation in progress |
| valid | output | 1 | One-cycle completion pulse |
| x_out | output | WIDTH | Final x (cosine or scaled magnitude) |
| y_out | output | WIDTH | Final y (sine or residual) |
| z_out | output | WIDTH | Final angle (residual or atan2) |

## Verification
Each operation's result is due exactly ITER rising edges after the edge that accepts `start`. The bench counts falling edges from that edge until `valid` shows, checks that the count is 16, and reads the outputs at that same falling edge. In the ignored-start and hold scenarios, the bench keeps counting falling edges after the pulse. This confirms that `valid` is low again one edge later and that the outputs stay fixed for several more cycles. All numeric expectations come from real-valued trigonometry in the bench, compared within the tolerances stated in R5 and R6.

// File: rtl/cordic_iter_pkg.sv
package cordic_iter_pkg;

  typedef enum logic {
    OP_ROTATE = 1'b0,
    OP_VECTOR = 1'b1
  } op_mode_e;

  // atan(2^-i) scaled by 2^30, rounded; for i >= 10 the cubic term is below half an LSB
  function automatic longint atan_q30(input int i);
    case (i)
      0: atan_q30 = 64'd843314857;
      1: atan_q30 = 64'd497837830;
      2: atan_q30 = 64'd263043837;
      3: atan_q30 = 64'd133525159;
      4: atan_q30 = 64'd67021687;
      5: atan_q30 = 64'd33543516;
      6: atan_q30 = 64'd16775851;
      7: atan_q30 = 64'd8388437;
      8: atan_q30 = 64'd4194283;
      9: atan_q30 = 64'd2097149;
      default: atan_q30 = (i <= 30) ? (64'sd1 <<< (30 - i)) : 64'sd0;
    endcase
  endfunction

endpackage

// File: rtl/cordic_atan_rom.sv
module cordic_atan_rom #(
  parameter int WIDTH = 32,
  parameter int ITER  = 16,
  localparam int IW   = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic [IW-1:0]           idx,
  output logic signed [WIDTH-1:0] angle
);
  import cordic_iter_pkg::*;

  logic signed [WIDTH-1:0] tab [ITER];

  // constants are held in Q2.30 and scaled to WIDTH-2 fraction bits
  for (genvar g = 0; g < ITER; g++) begin : g_tab
    localparam longint RAW = atan_q30(g) >>> (32 - WIDTH);
    assign tab[g] = WIDTH'(RAW);
  end

  assign angle = tab[idx];

endmodule

// File: rtl/cordic_micro_rot.sv
module cordic_micro_rot #(
  parameter int WIDTH = 32,
  parameter int SW    = 4
) (
  input  logic                    vec_mode,
  input  logic signed [WIDTH-1:0] x,
  input  logic signed [WIDTH-1:0] y,
  input  logic signed [WIDTH-1:0] z,
  input  logic [SW-1:0]           shift,
  input  logic signed [WIDTH-1:0] angle,
  output logic signed [WIDTH-1:0] xn,
  output logic signed [WIDTH-1:0] yn,
  output logic signed [WIDTH-1:0] zn
);
  logic signed [WIDTH-1:0] xs, ys;
  logic                    turn_pos;

  always_comb begin
    xs = x >>> shift;
    ys = y >>> shift;
    // rotation: follow sign of z; vectoring: oppose sign of y
    turn_pos = vec_mode ? y[WIDTH-1] : ~z[WIDTH-1];
    if (turn_pos) begin
      xn = x - ys;
      yn = y + xs;
      zn = z - angle;
    end else begin
      xn = x + ys;
      yn = y - xs;
      zn = z + angle;
    end
  end

endmodule

// File: rtl/cordic_seq.sv
module cordic_seq #(
  parameter int ITER = 16,
  localparam int IW  = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          accept,
  output logic          busy,
  output logic          valid,
  output logic [IW-1:0] cnt
);
  localparam logic [IW-1:0] LAST = IW'(ITER - 1);

  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      valid <= 1'b0;
      cnt   <= '0;
    end else begin
      valid <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (cnt == LAST) begin
          busy  <= 1'b0;
          valid <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  // R2
  busy_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && valid));
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && cnt == '0));
  // R2
  finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == LAST) |=> (valid && !busy));
  // R3
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && cnt != LAST) |=> (busy && cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/cordic_iter_engine.sv
module cordic_iter_engine #(
  parameter int WIDTH = 32,
  parameter int ITER  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    mode,
  input  logic signed [WIDTH-1:0] x_in,
  input  logic signed [WIDTH-1:0] y_in,
  input  logic signed [WIDTH-1:0] z_in,
  output logic                    busy,
  output logic                    valid,
  output logic signed [WIDTH-1:0] x_out,
  output logic signed [WIDTH-1:0] y_out,
  output logic signed [WIDTH-1:0] z_out
);
  import cordic_iter_pkg::*;

  localparam int IW = (ITER > 1) ? $clog2(ITER) : 1;

  logic                    accept;
  logic [IW-1:0]           cnt;
  op_mode_e                op_r;
  logic signed [WIDTH-1:0] xr, yr, zr;
  logic signed [WIDTH-1:0] xn, yn, zn, angle;
  logic                    fold;

  cordic_seq #(.ITER(ITER)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .accept (accept),
    .busy   (busy),
    .valid  (valid),
    .cnt    (cnt)
  );

  cordic_atan_rom #(.WIDTH(WIDTH), .ITER(ITER)) u_rom (
    .idx   (cnt),
    .angle (angle)
  );

  cordic_micro_rot #(.WIDTH(WIDTH), .SW(IW)) u_rot (
    .vec_mode (op_r == OP_VECTOR),
    .x        (xr),
    .y        (yr),
    .z        (zr),
    .shift    (cnt),
    .angle    (angle),
    .xn       (xn),
    .yn       (yn),
    .zn       (zn)
  );

  // vectoring pre-fold into the right half-plane
  assign fold = mode && x_in[WIDTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_r <= OP_ROTATE;
      xr   <= '0;
      yr   <= '0;
      zr   <= '0;
    end else if (accept) begin
      op_r <= op_mode_e'(mode);
      xr   <= fold ? -x_in : x_in;
      yr   <= fold ? -y_in : y_in;
      zr   <= z_in;
    end else if (busy) begin
      xr <= xn;
      yr <= yn;
      zr <= zn;
    end
  end

  assign x_out = xr;
  assign y_out = yr;
  assign z_out = zr;

  // R7
  fold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode && x_in[WIDTH-1]) |=> (x_out == -$past(x_in) && y_out == -$past(y_in)));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(x_out) && $stable(y_out) && $stable(z_out)));
  // R3
  busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (z_out == $past(zn)));

endmodule

// File: tb/test_cordic_iter_engine.sv
module test_cordic_iter_engine;
  localparam int  CLK_PERIOD = 10;
  localparam int  W = 32;
  localparam int  ITER = 16;
  localparam real SC = 1073741824.0;
  localparam real GAIN = 1.6467602578;
  localparam longint INV_K = 652032874;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
  logic signed [W-1:0] x_in = '0, y_in = '0, z_in = '0;
  logic busy, valid;
  logic signed [W-1:0] x_out, y_out, z_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  cordic_iter_engine #(.WIDTH(W), .ITER(ITER)) i_cordic_iter_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .x_in(x_in), .y_in(y_in), .z_in(z_in),
    .busy(busy), .valid(valid), .x_out(x_out), .y_out(y_out), .z_out(z_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint q(input real r);
    return longint'($rtoi(r * SC));
  endfunction

  task automatic chk_tol(input string req, input string what, input longint act,
                         input longint exp, input longint tol);
    longint d = act - exp;
    if (d < 0) d = -d;
    checks++;
    if (d > tol) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (tol %0d)", req, what, act, exp, tol);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
    chk_tol(req, what, act, exp, 0);
  endtask

  // drive at a falling edge; returns results at the falling edge showing valid
  task automatic run_op(input logic m, input longint xi, input longint yi, input longint zi,
                        output longint xo, output longint yo, output longint zo, output int lat);
    mode = m; x_in = xi[W-1:0]; y_in = yi[W-1:0]; z_in = zi[W-1:0]; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    xo = longint'(x_out); yo = longint'(y_out); zo = longint'(z_out);
  endtask

  task automatic t_reset;
    chk_eq("R1", "busy in reset", longint'(busy), 0);
    chk_eq("R1", "valid in reset", longint'(valid), 0);
    chk_eq("R1", "x_out in reset", longint'(x_out), 0);
    chk_eq("R1", "y_out in reset", longint'(y_out), 0);
    chk_eq("R1", "z_out in reset", longint'(z_out), 0);
  endtask

  task automatic t_rotate(input real a, input string req);
    longint xo, yo, zo; int lat;
    run_op(1'b0, INV_K, 0, q(a), xo, yo, zo, lat);
    chk_eq("R2", "latency", lat, ITER);
    chk_tol(req, "cos", xo, q($cos(a)), 40000);
    chk_tol(req, "sin", yo, q($sin(a)), 40000);
  endtask

  task automatic t_vector(input real xr, input real yr, input string req);
    longint xo, yo, zo; int lat;
    real ex, ey;
    ex = xr; ey = yr;
    if (xr < 0.0) begin ex = -xr; ey = -yr; end
    run_op(1'b1, q(xr), q(yr), 0, xo, yo, zo, lat);
    chk_eq("R2", "latency", lat, ITER);
    chk_tol(req, "magnitude", xo, q(GAIN * $sqrt(xr*xr + yr*yr)), 4096);
    chk_tol(req, "residual y", yo, 0, 40000);
    chk_tol(req, "angle", zo, q($atan2(ey, ex)), 40000);
  endtask

  // R3, R4: start during a run is ignored; results then hold
  task automatic t_ignore_and_hold;
    longint xo, yo, zo; int lat;
    mode = 1'b0; x_in = INV_K[W-1:0]; y_in = '0; z_in = q(0.5); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    mode = 1'b1; x_in = q(-0.3); y_in = q(0.2); z_in = q(1.0); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 5;
    while (!valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk_eq("R3", "latency with ignored start", lat, ITER);
    xo = longint'(x_out); yo = longint'(y_out); zo = longint'(z_out);
    chk_tol("R3", "cos kept", xo, q($cos(0.5)), 40000);
    chk_tol("R3", "sin kept", yo, q($sin(0.5)), 40000);
    @(negedge clk);
    chk_eq("R2", "valid single pulse", longint'(valid), 0);
    chk_eq("R2", "busy after done", longint'(busy), 0);
    repeat (3) @(negedge clk);
    chk_eq("R4", "x held", longint'(x_out), xo);
    chk_eq("R4", "y held", longint'(y_out), yo);
    chk_eq("R4", "z held", longint'(z_out), zo);
  endtask

  // R7: 180 degrees folds onto 0 degrees
  task automatic t_fold;
    longint xa, ya, za, xb, yb, zb; int la, lb;
    run_op(1'b1, q(0.5), 0, 0, xa, ya, za, la);
    run_op(1'b1, q(-0.5), 0, 0, xb, yb, zb, lb);
    chk_eq("R7", "angle 180 equals angle 0", zb, za);
    chk_eq("R7", "magnitude 180 equals 0", xb, xa);
    chk_tol("R7", "angle of 180 deg", zb, 0, 40000);
  endtask

  // R9: start presented in the valid cycle
  task automatic t_back_to_back;
    longint xo, yo, zo; int lat;
    run_op(1'b0, INV_K, 0, q(0.9), xo, yo, zo, lat);
    run_op(1'b0, INV_K, 0, q(-0.9), xo, yo, zo, lat);
    chk_eq("R9", "back-to-back latency", lat, ITER);
    chk_tol("R9", "back-to-back sin", yo, q($sin(-0.9)), 40000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rotate(0.0, "R5");
    t_rotate(PI/6.0, "R5");
    t_rotate(-PI/4.0, "R8");
    t_rotate(1.2, "R5");
    t_rotate(-1.5, "R8");
    t_vector(0.5, 0.3, "R6");
    t_vector(0.2, -0.55, "R8");
    t_vector(-0.4, 0.3, "R7");
    t_vector(-0.35, -0.45, "R7");
    t_fold();
    t_ignore_and_hold();
    t_back_to_back();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule